// File: doc/BRIEF.md
# Memory Field Extension Controller

This block widens a 12-bit word address to 15 bits by placing a 3-bit field number above it. That gives eight fields of 4096 words each, 32,768 words in total. It holds two field registers. The code field serves instruction fetches, direct operand accesses and the fetch of an indirect pointer. The data field serves only the final operand of an indirect access. The processor reports the kind of each access on a 2-bit strobe, and the block returns the full 15-bit address in the same cycle.

Field changes arrive as I/O transfer instructions in the range 6200–6277 (octal). A data-field change takes effect on the next cycle. A code-field change is held in a pending buffer and is moved into the code field only when the processor reports a completed jump or subroutine call. The processor can read the field registers into its accumulator. When an interrupt is taken, both fields are copied into a 6-bit save register and then cleared. A restore instruction brings them back, with the code part once more waiting for the next jump. Interrupts are refused while a code-field change is pending, so that deferred state is never lost.

Top module: `mem_field_ext`

## Requirements
- R1: After reset, the code field, data field, pending buffer and save register are all 0, and `irq_ok` is 1.
- R2: For `acc_kind` 0 (fetch), 1 (direct operand) and 2 (indirect pointer), `phys_addr` = {code field, `addr_lo`} in the same cycle.
- R3: For `acc_kind` 3 (indirect final operand), `phys_addr` = {data field, `addr_lo`} in the same cycle.
- R4: An IOT word 62X1 or 62X3 (octal; X in bits 5:3, function in bits 2:0) sets the data field to X, visible on `df_now` from the next cycle.
- R5: An IOT word 62X2 or 62X3 loads X into the pending buffer and leaves `if_now` unchanged. On a later `jump_done`, the pending value becomes the code field on the next cycle. A `jump_done` with nothing pending leaves the code field unchanged.
- R6: IOT 6214 drives `ac_out` = `ac_in` OR (data field << 3), and 6224 does the same with the code field. Both raise `ac_wr` combinationally.
- R7: IOT 6234 drives `ac_out` = `ac_in` OR save register, with the saved code field in bits 5:3 and the saved data field in bits 2:0. It raises `ac_wr`.
- R8: IOT 6244 loads the data field from save bits 2:0 at once. It places save bits 5:3 in the pending buffer, to be applied at the next `jump_done`.
- R9: An accepted `irq_take` copies {code, data} fields into the save register. On the next cycle, both fields and the pending buffer are cleared.
- R10: While a code-field change is pending, `irq_ok` is 0 and `irq_take` has no effect.
- R11: Any other IOT word (outside 62xx, function 0, 5, 6 or 7, or function 4 with X outside 1–4) changes no field and leaves `ac_wr` 0 and `ac_out` = `ac_in`.
- R12: If a jump and a pending-load IOT occur in the same cycle, the jump applies the old pending value and the new value stays pending. An accepted interrupt overrides both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_kind | input | 2 | Access kind: 0 fetch, 1 direct, 2 pointer, 3 indirect operand |
| addr_lo | input | 12 | Address within a field |
| phys_addr | output | 15 | Extended address |
| iot_valid | input | 1 | An IOT instruction executes this cycle |
| iot_word | input | 12 | The IOT instruction word |
| ac_in | input | 12 | Accumulator value |
| ac_out | output | 12 | Accumulator value after a read IOT |
| ac_wr | output | 1 | `ac_out` should be written to the accumulator |
| jump_done | input | 1 | A JMP or JMS completed this cycle |
| irq_take | input | 1 | Processor takes an interrupt |
| irq_ok | output | 1 | Interrupts may be taken |
| if_now | output | 3 | Current code field |
| df_now | output | 3 | Current data field |

## Verification
The address, `ac_out` and `ac_wr` are combinational and are due in the same cycle as the stimulus. The bench sets its inputs on a falling edge and compares these outputs 1 ns later. Field, pending and save updates appear one rising edge after the stimulus. The reference model therefore advances only after that rising edge, and `if_now`, `df_now` and `irq_ok` are compared on the following falling edge. A deferred code-field change is checked to stay hidden across many cycles until the jump strobe arrives.

// File: rtl/mem_field_ext.sv
module mem_field_ext #(
  parameter int AW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      acc_kind,
  input  logic [AW-1:0]   addr_lo,
  output logic [AW+2:0]   phys_addr,
  input  logic            iot_valid,
  input  logic [11:0]     iot_word,
  input  logic [11:0]     ac_in,
  output logic [11:0]     ac_out,
  output logic            ac_wr,
  input  logic            jump_done,
  input  logic            irq_take,
  output logic            irq_ok,
  output logic [2:0]      if_now,
  output logic [2:0]      df_now
);
  localparam logic [1:0] KIND_OPND = 2'd3;

  logic [2:0] if_r, df_r, pend_f;
  logic       pend_v;
  logic [5:0] save_r;

  wire       fld_op = iot_valid && (iot_word[11:6] == 6'o62);
  wire [2:0] sel    = iot_word[5:3];
  wire [2:0] fn     = iot_word[2:0];
  wire set_df = fld_op && (fn == 3'd1 || fn == 3'd3);
  wire set_if = fld_op && (fn == 3'd2 || fn == 3'd3);
  wire rd_df  = fld_op && fn == 3'd4 && sel == 3'd1;
  wire rd_if  = fld_op && fn == 3'd4 && sel == 3'd2;
  wire rd_sv  = fld_op && fn == 3'd4 && sel == 3'd3;
  wire rst_sv = fld_op && fn == 3'd4 && sel == 3'd4;
  wire irq_go = irq_take && !pend_v;

  assign irq_ok    = !pend_v;
  assign if_now    = if_r;
  assign df_now    = df_r;
  assign phys_addr = {(acc_kind == KIND_OPND) ? df_r : if_r, addr_lo};
  assign ac_wr     = rd_df | rd_if | rd_sv;
  assign ac_out    = ac_in
                   | (rd_df ? {6'd0, df_r, 3'd0} : 12'd0)
                   | (rd_if ? {6'd0, if_r, 3'd0} : 12'd0)
                   | (rd_sv ? {6'd0, save_r}     : 12'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if_r <= '0; df_r <= '0; pend_f <= '0; pend_v <= 1'b0; save_r <= '0;
    end else if (irq_go) begin
      save_r <= {if_r, df_r};
      if_r <= '0; df_r <= '0; pend_f <= '0; pend_v <= 1'b0;
    end else begin
      if (jump_done && pend_v) if_r <= pend_f;
      if (set_df)      df_r <= sel;
      else if (rst_sv) df_r <= save_r[2:0];
      if (set_if) begin
        pend_f <= sel; pend_v <= 1'b1;
      end else if (rst_sv) begin
        pend_f <= save_r[5:3]; pend_v <= 1'b1;
      end else if (jump_done) begin
        pend_v <= 1'b0;
      end
    end
  end

  // R4
  df_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_df && !irq_go) |=> (df_now == $past(iot_word[5:3])));
  // R5
  if_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_if && !jump_done && !irq_go) |=> $stable(if_now));
  // R5
  if_on_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_done && !irq_ok && !irq_take) |=> (if_now == $past(pend_f)));
  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_ok) |=> (if_now == 3'd0 && df_now == 3'd0 && irq_ok));
  // R10
  irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !irq_ok && !jump_done && !iot_valid) |=> ($stable(df_now) && $stable(if_now) && !irq_ok));
endmodule

// File: tb/test_mem_field_ext.sv
`timescale 1ns/1ps
module test_mem_field_ext;
  logic clk = 0, rst_n = 0;
  logic [1:0] acc_kind = 0;
  logic [11:0] addr_lo = 0, iot_word = 0, ac_in = 0, ac_out;
  logic [14:0] phys_addr;
  logic iot_valid = 0, jump_done = 0, irq_take = 0, ac_wr, irq_ok;
  logic [2:0] if_now, df_now;
  int n_run = 0, n_fail = 0;
  logic [2:0] mi = 0, md = 0, mpf = 0;
  logic mpv = 0;
  logic [5:0] msv = 0;

  always #2.5 clk = ~clk;

  mem_field_ext i_mem_field_ext (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_ac(logic [11:0] w, logic [11:0] a);
    if (w == 12'o6214) return a | {6'd0, md, 3'd0};
    if (w == 12'o6224) return a | {6'd0, mi, 3'd0};
    if (w == 12'o6234) return a | {6'd0, msv};
    return a;
  endfunction

  function automatic bit is_rd(logic [11:0] w);
    return w == 12'o6214 || w == 12'o6224 || w == 12'o6234;
  endfunction

  task automatic chk_state(string tag);
    @(negedge clk); #1;
    chk({tag, " if"}, 16'(if_now), 16'(mi));
    chk({tag, " df"}, 16'(df_now), 16'(md));
    chk("R10 irq_ok", 16'(irq_ok), 16'(!mpv));
  endtask

  task automatic step(logic [1:0] k, logic [11:0] a, logic v, logic [11:0] w,
                      logic [11:0] acv, logic j, logic q);
    logic [2:0] x, f, ni, nd;
    @(negedge clk);
    acc_kind = k; addr_lo = a; iot_valid = v; iot_word = w; ac_in = acv;
    jump_done = j; irq_take = q;
    #1;
    chk(k == 2'd3 ? "R3 addr" : "R2 addr", 16'(phys_addr), 16'({k == 2'd3 ? md : mi, a}));
    chk(v && is_rd(w) ? "R6/R7 ac" : "R11 ac", 16'(ac_out), 16'(v ? exp_ac(w, acv) : acv));
    chk("R11 ac_wr", 16'(ac_wr), 16'(v && is_rd(w)));
    chk("R5 if", 16'(if_now), 16'(mi));
    chk("R4 df", 16'(df_now), 16'(md));
    chk("R10 irq_ok", 16'(irq_ok), 16'(!mpv));
    @(posedge clk);
    x = w[5:3]; f = w[2:0];
    if (q && !mpv) begin
      msv = {mi, md}; mi = 0; md = 0; mpf = 0; mpv = 0;
    end else begin
      ni = (j && mpv) ? mpf : mi;
      nd = md;
      if (v && w[11:6] == 6'o62) begin
        if (f == 1 || f == 3) nd = x;
        if (f == 4 && x == 4) nd = msv[2:0];
        if (f == 2 || f == 3) begin mpf = x; mpv = 1; end
        else if (f == 4 && x == 4) begin mpf = msv[5:3]; mpv = 1; end
        else if (j) mpv = 0;
      end else if (j) mpv = 0;
      mi = ni; md = nd;
    end
    #1;
    iot_valid = 0; jump_done = 0; irq_take = 0;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1;
    chk_state("R1");
    step(2'd0, 12'o1234, 1, 12'o6234, 12'o7000, 0, 0);           // R1 save is 0
    // R4 data field immediate
    step(2'd3, 12'o0055, 1, 12'o6251, 12'd0, 0, 0);
    chk_state("R4");
    step(2'd3, 12'o0055, 0, 12'd0, 12'd0, 0, 0);                  // R3
    // R5 deferral over several cycles
    step(2'd0, 12'o0200, 1, 12'o6262, 12'd0, 0, 0);
    repeat (4) step(2'd1, 12'o0300, 0, 12'd0, 12'd0, 0, 0);
    step(2'd0, 12'o0200, 0, 12'd0, 12'd0, 0, 1);                  // R10 refused
    chk_state("R10");
    step(2'd0, 12'o0200, 0, 12'd0, 12'd0, 1, 0);
    chk_state("R5");
    step(2'd0, 12'o0200, 0, 12'd0, 12'd0, 1, 0);                  // R5 jump no pending
    chk_state("R5");
    step(2'd0, 12'd0, 1, 12'o6214, 12'o7001, 0, 0);               // R6
    step(2'd0, 12'd0, 1, 12'o6224, 12'o0001, 0, 0);               // R6
    // R9 interrupt save/clear
    step(2'd2, 12'o0010, 0, 12'd0, 12'd0, 0, 1);
    chk_state("R9");
    step(2'd0, 12'd0, 1, 12'o6234, 12'd0, 0, 0);                  // R7
    // R8 restore
    step(2'd0, 12'd0, 1, 12'o6244, 12'd0, 0, 0);
    chk_state("R8");
    step(2'd0, 12'd0, 0, 12'd0, 12'd0, 1, 0);
    chk_state("R8");
    // R11 ignored words
    step(2'd0, 12'd0, 1, 12'o6275, 12'o0123, 0, 0);
    step(2'd0, 12'd0, 1, 12'o6254, 12'o0123, 0, 0);
    step(2'd0, 12'd0, 1, 12'o6171, 12'o0123, 0, 0);
    chk_state("R11");
    // R12 jump with new pending load
    step(2'd0, 12'd0, 1, 12'o6232, 12'd0, 0, 0);
    step(2'd0, 12'd0, 1, 12'o6252, 12'd0, 1, 0);
    chk_state("R12");
    step(2'd0, 12'd0, 0, 12'd0, 12'd0, 1, 0);
    chk_state("R12");
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] w;
      w = ($urandom % 2) ? {6'o62, 3'($urandom), 3'($urandom)} : 12'($urandom);
      step(2'($urandom), 12'($urandom), 1'($urandom % 3 != 0), w, 12'($urandom),
           1'($urandom % 6 == 0), 1'($urandom % 8 == 0));
    end
    chk_state("R12");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule